// File: doc/BRIEF.md
# Handshaked Multi-Source Sample Output Port

This block gathers complex baseband samples from six upstream gain-control channels and streams them over a single 16-bit parallel bus in the port clock domain. Each source owns a one-deep holding register with a pending bit. A fixed-priority picker chooses the next sample to send, and a word sequencer then emits the words of that sample under a request/acknowledge handshake.

Two bus formats are available. In packed mode the upper bytes of I and Q share one word. In interleaved mode a full-width I word is followed by a full-width Q word. An optional gain word can follow the sample data. Every word on the bus is tagged with its source channel, plus a flag that marks I/Q data or a flag that marks a gain word. Words are two's complement. Once a sample starts, its words leave together: priority is decided again only between samples.

Top module: `sample_out_port`

## Requirements
- R1: While reset is low, `req_out`, `port_data`, `iq_flag`, `gain_flag`, `src_chan` and `ovf_flags` are all zero.
- R2: `req_out` is high in every cycle in which any source holds a pending sample or a word of a started sample is on the bus, and low otherwise.
- R3: `ack_in` is sampled on the rising edge of `pclk`. With `ack_in` held high, the first word of a sample appears one cycle after `req_out` rises.
- R4: In packed mode (`interleave_en` = 0), one word carries I[15:8] in bits 15:8 and Q[15:8] in bits 7:0, with `iq_flag` high.
- R5: In interleaved mode (`interleave_en` = 1), the full I word and then the full Q word go out on consecutive shifting cycles. `iq_flag` is high for the I word only.
- R6: With `gain_en` = 1, the source's gain word follows the last data word. During that word `gain_flag` is high and `iq_flag` is low. The two flags are never high together.
- R7: During every word, `src_chan` carries the index (0 to 5) of the source that produced it.
- R8: Among pending sources the lowest index is served first. A started sample is never interrupted by another source.
- R9: A word on the bus is consumed at a rising edge where `ack_in` is high. While `ack_in` is low the word, its flags and its channel stay unchanged, and shifting resumes from that same word.
- R10: When no word is being shifted, `port_data` is zero and `iq_flag`, `gain_flag` and `src_chan` are zero.
- R11: A new sample that arrives while the source's pending bit is still set overwrites the held sample and sets that source's bit in `ovf_flags`. The bit then stays set until reset.
- R12: `interleave_en` and `gain_en` are captured when a sample starts. A change in the middle of a sample does not alter the rest of that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Port clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_in | input | 1 | Acknowledge from the receiver; high allows shifting |
| interleave_en | input | 1 | 1 selects interleaved I then Q, 0 selects packed I/Q |
| gain_en | input | 1 | 1 appends the gain word to each sample |
| smp_vld | input | 6 | Per-source strobe: a new sample is present this cycle |
| smp_i | input | 96 | I samples, source c in bits c*16 +: 16 |
| smp_q | input | 96 | Q samples, same layout |
| smp_gain | input | 96 | Gain words, same layout |
| req_out | output | 1 | Request: data pending or being shifted |
| port_data | output | 16 | Output data bus |
| iq_flag | output | 1 | High while an I-bearing word is on the bus |
| gain_flag | output | 1 | High while a gain word is on the bus |
| src_chan | output | 3 | Source index of the word on the bus |
| ovf_flags | output | 6 | Sticky per-source overwrite flags |

## Verification
The bench goes after an acknowledge drop in the middle of an interleaved sample with gain. A design that advanced on a low acknowledge would skip the Q word, and one that restarted would send I twice. It loads a low-priority source and then a higher one while the first is in flight. A port that decided priority on every word would splice channel 0 into channel 4's sample. It also sends back-to-back arrivals to a stalled source, which catches a lost overflow flag or a stale sample on the bus, and it flips the mode in the middle of a sample, which exposes a sequencer that reads the live mode pins. Long random stretches of arrivals, acknowledge gaps and mode changes are compared word by word against a queue model.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Kind of word currently presented on the bus
  typedef enum logic [1:0] {
    WK_PACK = 2'd0,
    WK_I    = 2'd1,
    WK_Q    = 2'd2,
    WK_GAIN = 2'd3
  } word_kind_e;

  // Index of the final word of one sample for the given format
  function automatic logic [1:0] last_slot(input logic il, input logic ge);
    return 2'(il) + 2'(ge);
  endfunction

  // Which word a slot index holds for the given format
  function automatic word_kind_e slot_kind(input logic [1:0] slot, input logic il);
    if (slot == 2'd0) return il ? WK_I : WK_PACK;
    if (slot == 2'd1 && il) return WK_Q;
    return WK_GAIN;
  endfunction

endpackage

// File: rtl/sop_hold.sv
module sop_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          take_i,
  input  logic [DW-1:0] din_i,
  input  logic [DW-1:0] din_q,
  input  logic [DW-1:0] din_g,
  output logic          pend_o,
  output logic          ovf_o,
  output logic [DW-1:0] held_i,
  output logic [DW-1:0] held_q,
  output logic [DW-1:0] held_g
);

  // An arrival overwrites a sample the sequencer is not taking this cycle
  logic clobber_w;
  assign clobber_w = load_i && pend_o && !take_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      ovf_o  <= 1'b0;
      held_i <= '0;
      held_q <= '0;
      held_g <= '0;
    end else begin
      if (load_i) begin
        pend_o <= 1'b1;
        held_i <= din_i;
        held_q <= din_q;
        held_g <= din_g;
      end else if (take_i) begin
        pend_o <= 1'b0;
      end
      if (clobber_w) ovf_o <= 1'b1;
    end
  end

endmodule

// File: rtl/sop_prio.sv
module sop_prio #(
  parameter int NCH = 6,
  parameter int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] pend_i,
  output logic           any_o,
  output logic [CHW-1:0] pick_o
);

  // Scan from the lowest priority upward so the lowest index wins
  always_comb begin
    pick_o = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (pend_i[c]) pick_o = CHW'(c);
    end
  end

  assign any_o = |pend_i;

endmodule

// File: rtl/sop_seq.sv
module sop_seq
  import sop_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 16,
  parameter int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_i,
  input  logic              any_i,
  input  logic [CHW-1:0]    pick_i,
  input  logic [NCH*DW-1:0] held_i,
  input  logic [NCH*DW-1:0] held_q,
  input  logic [NCH*DW-1:0] held_g,
  input  logic              il_i,
  input  logic              ge_i,
  output logic              start_o,
  output logic              busy_o,
  output logic [DW-1:0]     data_o,
  output logic              iq_o,
  output logic              gain_o,
  output logic [CHW-1:0]    chan_o
);

  localparam int HW = DW / 2;

  logic           busy_q;
  logic [1:0]     slot_q;
  logic [1:0]     last_q;
  logic           il_q;
  logic [CHW-1:0] chan_q;
  logic [DW-1:0]  cur_i, cur_q, cur_g;
  logic           at_last_w;
  word_kind_e     kind_w;

  assign at_last_w = (slot_q == last_q);
  // A new sample may begin when the port is empty or its final word leaves
  assign start_o   = ack_i && any_i && (!busy_q || at_last_w);
  assign busy_o    = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      last_q <= '0;
      il_q   <= 1'b0;
      chan_q <= '0;
      cur_i  <= '0;
      cur_q  <= '0;
      cur_g  <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      slot_q <= '0;
      last_q <= last_slot(il_i, ge_i);
      il_q   <= il_i;
      chan_q <= pick_i;
      cur_i  <= held_i[pick_i*DW +: DW];
      cur_q  <= held_q[pick_i*DW +: DW];
      cur_g  <= held_g[pick_i*DW +: DW];
    end else if (ack_i && busy_q) begin
      if (at_last_w) busy_q <= 1'b0;
      else           slot_q <= slot_q + 2'd1;
    end
  end

  assign kind_w = slot_kind(slot_q, il_q);

  always_comb begin
    data_o = '0;
    iq_o   = 1'b0;
    gain_o = 1'b0;
    chan_o = '0;
    if (busy_q) begin
      chan_o = chan_q;
      unique case (kind_w)
        WK_PACK: begin
          data_o = {cur_i[DW-1 -: HW], cur_q[DW-1 -: HW]};
          iq_o   = 1'b1;
        end
        WK_I: begin
          data_o = cur_i;
          iq_o   = 1'b1;
        end
        WK_Q:    data_o = cur_q;
        WK_GAIN: begin
          data_o = cur_g;
          gain_o = 1'b1;
        end
        default: data_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/sample_out_port.sv
module sample_out_port #(
  parameter  int NCH = 6,
  parameter  int DW  = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              pclk,
  input  logic              rst_n,
  input  logic              ack_in,
  input  logic              interleave_en,
  input  logic              gain_en,
  input  logic [NCH-1:0]    smp_vld,
  input  logic [NCH*DW-1:0] smp_i,
  input  logic [NCH*DW-1:0] smp_q,
  input  logic [NCH*DW-1:0] smp_gain,
  output logic              req_out,
  output logic [DW-1:0]     port_data,
  output logic              iq_flag,
  output logic              gain_flag,
  output logic [CHW-1:0]    src_chan,
  output logic [NCH-1:0]    ovf_flags
);

  // Named internal events, also observed by the checker
  logic              start_w;
  logic              busy_w;
  logic              any_w;
  logic [CHW-1:0]    pick_w;
  logic [NCH-1:0]    pend_w;
  logic [NCH-1:0]    take_w;
  logic [NCH*DW-1:0] held_i_w, held_q_w, held_g_w;

  for (genvar c = 0; c < NCH; c++) begin : g_src
    assign take_w[c] = start_w && (pick_w == CHW'(c));

    sop_hold #(.DW(DW)) u_hold (
      .clk    (pclk),
      .rst_n  (rst_n),
      .load_i (smp_vld[c]),
      .take_i (take_w[c]),
      .din_i  (smp_i[c*DW +: DW]),
      .din_q  (smp_q[c*DW +: DW]),
      .din_g  (smp_gain[c*DW +: DW]),
      .pend_o (pend_w[c]),
      .ovf_o  (ovf_flags[c]),
      .held_i (held_i_w[c*DW +: DW]),
      .held_q (held_q_w[c*DW +: DW]),
      .held_g (held_g_w[c*DW +: DW])
    );
  end

  sop_prio #(.NCH(NCH), .CHW(CHW)) u_prio (
    .pend_i (pend_w),
    .any_o  (any_w),
    .pick_o (pick_w)
  );

  sop_seq #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_seq (
    .clk     (pclk),
    .rst_n   (rst_n),
    .ack_i   (ack_in),
    .any_i   (any_w),
    .pick_i  (pick_w),
    .held_i  (held_i_w),
    .held_q  (held_q_w),
    .held_g  (held_g_w),
    .il_i    (interleave_en),
    .ge_i    (gain_en),
    .start_o (start_w),
    .busy_o  (busy_w),
    .data_o  (port_data),
    .iq_o    (iq_flag),
    .gain_o  (gain_flag),
    .chan_o  (src_chan)
  );

  assign req_out = busy_w || any_w;

endmodule

// File: rtl/sop_chk.sv
module sop_chk #(
  parameter int NCH = 6,
  parameter int DW  = 16,
  parameter int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ack,
  input logic           req,
  input logic [DW-1:0]  data,
  input logic           iq,
  input logic           gain,
  input logic [CHW-1:0] chan,
  input logic [NCH-1:0] ovf,
  input logic           busy,
  input logic           start,
  input logic [CHW-1:0] pick,
  input logic [NCH-1:0] pend,
  input logic [NCH-1:0] take
);

  logic [NCH-1:0] below_w;
  assign below_w = (NCH'(1) << pick) - NCH'(1);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (data == '0 && !iq && !gain && chan == '0));

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(iq && gain));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack) |=> (busy && $stable(data) && $stable(iq) && $stable(gain) && $stable(chan)));

  // R7
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(chan) < NCH));

  // R8
  prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ((pend & below_w) == '0 && pend[pick]));

  // R8
  take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  // R2
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> req);

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf != '0) |=> ((ovf & $past(ovf)) == $past(ovf)));

endmodule

bind sample_out_port sop_chk #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_sop_chk (
  .clk   (pclk),
  .rst_n (rst_n),
  .ack   (ack_in),
  .req   (req_out),
  .data  (port_data),
  .iq    (iq_flag),
  .gain  (gain_flag),
  .chan  (src_chan),
  .ovf   (ovf_flags),
  .busy  (busy_w),
  .start (start_w),
  .pick  (pick_w),
  .pend  (pend_w),
  .take  (take_w)
);

// File: tb/test_sample_out_port.sv
module test_sample_out_port;
  localparam int NCH = 6;
  localparam int DW  = 16;
  localparam int CHW = 3;

  logic pclk = 1'b0;
  logic rst_n = 1'b0;
  logic ack = 1'b0, il = 1'b0, ge = 1'b0;
  logic [NCH-1:0] vld = '0;
  logic [NCH*DW-1:0] si = '0, sq = '0, sg = '0;
  logic req, iqf, gnf;
  logic [DW-1:0] pdata;
  logic [CHW-1:0] chan;
  logic [NCH-1:0] ovf;

  always #4 pclk = ~pclk;

  sample_out_port i_sample_out_port (
    .pclk(pclk), .rst_n(rst_n), .ack_in(ack), .interleave_en(il), .gain_en(ge),
    .smp_vld(vld), .smp_i(si), .smp_q(sq), .smp_gain(sg),
    .req_out(req), .port_data(pdata), .iq_flag(iqf), .gain_flag(gnf),
    .src_chan(chan), .ovf_flags(ovf)
  );

  int checks = 0, fails = 0, cycles = 0;

  // Reference model: per-source slots plus a queue of words still to go out
  typedef struct packed {
    logic [DW-1:0]  d;
    logic           iq;
    logic           g;
    logic [CHW-1:0] ch;
    logic [1:0]     k;   // 0 packed, 1 I/Q, 2 gain
  } wrd_t;
  wrd_t wq[$];
  bit m_pend[NCH];
  bit m_ovf[NCH];
  logic [DW-1:0] m_i[NCH], m_q[NCH], m_g[NCH];
  int pk;

  always @(posedge pclk) begin
    if (!rst_n) begin
      wq.delete();
      for (int c = 0; c < NCH; c++) begin
        m_pend[c] = 0; m_ovf[c] = 0;
      end
    end else begin
      if (ack && wq.size() > 0) void'(wq.pop_front());
      if (ack && wq.size() == 0) begin
        pk = -1;
        for (int c = 0; c < NCH; c++) if (m_pend[c] && pk < 0) pk = c;
        if (pk >= 0) begin
          if (il) begin
            wq.push_back('{d: m_i[pk], iq: 1'b1, g: 1'b0, ch: CHW'(pk), k: 2'd1});
            wq.push_back('{d: m_q[pk], iq: 1'b0, g: 1'b0, ch: CHW'(pk), k: 2'd1});
          end else begin
            wq.push_back('{d: {m_i[pk][15:8], m_q[pk][15:8]}, iq: 1'b1, g: 1'b0, ch: CHW'(pk), k: 2'd0});
          end
          if (ge) wq.push_back('{d: m_g[pk], iq: 1'b0, g: 1'b1, ch: CHW'(pk), k: 2'd2});
          m_pend[pk] = 0;
        end
      end
      for (int c = 0; c < NCH; c++) begin
        if (vld[c]) begin
          if (m_pend[c]) m_ovf[c] = 1;
          m_pend[c] = 1;
          m_i[c] = si[c*DW +: DW];
          m_q[c] = sq[c*DW +: DW];
          m_g[c] = sg[c*DW +: DW];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    wrd_t e;
    bit anyp;
    logic [NCH-1:0] eo;
    string tag;
    anyp = 0;
    for (int c = 0; c < NCH; c++) begin
      anyp |= m_pend[c];
      eo[c] = m_ovf[c];
    end
    if (wq.size() > 0) begin
      e = wq[0];
      tag = (e.k == 2'd0) ? "R4" : (e.k == 2'd1) ? "R5" : "R6";
    end else begin
      e = '0;
      tag = "R10";
    end
    chk(pdata == e.d, tag, "data", pdata, e.d);
    chk(iqf == e.iq && gnf == e.g, tag, "flags", {iqf, gnf}, {e.iq, e.g});
    chk(chan == e.ch, "R7", "chan", chan, e.ch);
    chk(req == (anyp || wq.size() > 0), "R2", "req", req, anyp || wq.size() > 0);
    chk(ovf == eo, "R11", "ovf", ovf, eo);
  endtask

  task automatic cyc();
    @(negedge pclk);
    compare();
    vld = '0;
  endtask

  task automatic put(input int c, input logic [DW-1:0] i, input logic [DW-1:0] q,
                     input logic [DW-1:0] g);
    vld[c] = 1'b1;
    si[c*DW +: DW] = i;
    sq[c*DW +: DW] = q;
    sg[c*DW +: DW] = g;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge pclk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R2 watchdog: actual %0d cycles expected below 100000", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    logic [CHW-1:0] seen[3];
    repeat (3) @(negedge pclk);
    // R1 reset state
    chk(req == 0 && pdata == 0 && !iqf && !gnf && chan == 0 && ovf == 0,
        "R1", "reset outputs", {req, pdata, iqf, gnf, chan, ovf}, 0);
    rst_n = 1'b1;
    cyc();

    // R3 / R4: ack held high, packed sample from source 2
    ack = 1; il = 0; ge = 0;
    put(2, 16'h1234, 16'hABCD, 16'h0055);
    cyc();
    chk(req && !iqf, "R3", "req before data", {req, iqf}, 2'b10);
    cyc();
    chk(iqf && chan == 2 && pdata == 16'h12AB, "R4", "packed word", pdata, 16'h12AB);
    cyc();
    chk(!req && pdata == 0, "R10", "idle after sample", pdata, 0);

    // R8: three sources pending under a stalled ack
    ack = 0;
    put(5, 16'h5500, 16'h5501, 0); put(3, 16'h3300, 16'h3301, 0); put(1, 16'h1100, 16'h1101, 0);
    cyc();
    cyc();
    chk(req && !iqf, "R9", "no shift while ack low", iqf, 0);
    ack = 1;
    for (int n = 0; n < 3; n++) begin
      cyc();
      seen[n] = chan;
    end
    chk(seen[0] == 1 && seen[1] == 3 && seen[2] == 5, "R8", "service order",
        {seen[0], seen[1], seen[2]}, {3'd1, 3'd3, 3'd5});
    cyc();

    // R8 / R5 / R6: lower source in flight is not interrupted by source 0
    il = 1; ge = 1;
    put(4, 16'h4441, 16'h4442, 16'h4443);
    cyc();
    put(0, 16'h0A01, 16'h0A02, 16'h0A03);
    cyc();
    chk(chan == 4 && iqf && pdata == 16'h4441, "R5", "I word", pdata, 16'h4441);
    cyc();
    chk(chan == 4 && !iqf && pdata == 16'h4442, "R8", "sample not interrupted", chan, 4);
    cyc();
    chk(gnf && !iqf && pdata == 16'h4443, "R6", "gain word", pdata, 16'h4443);
    repeat (4) cyc();

    // R9: ack drop in the middle of a sample
    put(3, 16'h7001, 16'h7002, 16'h7003);
    cyc();
    cyc();
    ack = 0;
    cyc();
    chk(pdata == 16'h7001 && iqf, "R9", "word held", pdata, 16'h7001);
    cyc();
    ack = 1;
    cyc();
    chk(pdata == 16'h7002 && !iqf, "R9", "resume at Q", pdata, 16'h7002);
    repeat (3) cyc();

    // R11: overwrite of a pending sample
    ack = 0; il = 0; ge = 0;
    put(4, 16'hAA00, 16'hBB00, 0);
    cyc();
    put(4, 16'hCC00, 16'hDD00, 0);
    cyc();
    chk(ovf == 6'b010000, "R11", "overflow set", ovf, 6'b010000);
    ack = 1;
    cyc();
    chk(pdata == 16'hCCDD && chan == 4, "R11", "newer sample kept", pdata, 16'hCCDD);
    cyc();
    chk(ovf == 6'b010000, "R11", "overflow sticky", ovf, 6'b010000);

    // R12: mode change in the middle of a sample
    il = 1; ge = 0;
    put(1, 16'h1111, 16'h2222, 16'h3333);
    cyc();
    cyc();
    il = 0; ge = 1;
    cyc();
    chk(pdata == 16'h2222 && !iqf && !gnf, "R12", "format kept", pdata, 16'h2222);
    cyc();
    chk(!req && pdata == 0, "R12", "no gain appended", pdata, 0);

    // Mixed random traffic compared every cycle
    for (int n = 0; n < 3000; n++) begin
      ack = ($urandom % 4) != 0;
      if ((n % 23) == 0) begin
        il = $urandom % 2;
        ge = $urandom % 2;
      end
      for (int c = 0; c < NCH; c++)
        if (($urandom % 9) == 0) put(c, 16'($urandom), 16'($urandom), 16'($urandom));
      cyc();
    end

    ack = 1;
    repeat (40) cyc();
    chk(!req, "R2", "drained", req, 0);
    summary();
    $finish;
  end

endmodule